// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is an 8-pin general-purpose I/O port sitting on a simple register bus. Each pin has a direction bit: a pin marked as an output drives the stored data bit, and a pin marked as an input drives a constant high level while its external level is sampled into the data register through a two-flop synchronizer.

The data register is reachable through a 1 KB window of offsets. Within that window, address bits [9:2] are used as a per-bit mask, so software can read or write any subset of pins in a single access, without a read-modify-write sequence. Each output also has a one-cycle change strobe that fires whenever its driven level actually flips.

Top module: `gpio_masked_port`

## Requirements
- R1: Any offset in 0x000..0x3FF selects the data register; a read returns the stored data ANDed with the mask taken from address bits [9:2], with every other bit of the read word zero.
- R2: A write in the data window changes only those data bits whose mask bit (address bits [9:2]) and direction bit are both 1; all other output-pin bits keep their value.
- R3: Software writes never change the data bit of a pin whose direction bit is 0; that bit instead follows the external pin level, which becomes readable after the third rising clock edge after the pin changes.
- R4: The direction register lives at offset 0x400, holds 8 bits (1 = output, 0 = input), reads back what was written, and resets to 0.
- R5: On the cycle after a data or direction update, each pin_out bit equals the data bit when the pin is an output and 1 when the pin is an input.
- R6: A pin_toggle bit is 1 for exactly those cycles in which the matching pin_out bit differs from its value in the previous cycle.
- R7: During reset pin_out is 0 and pin_toggle is 0; after the first rising edge with reset released, pin_out is 0xFF and all eight pin_toggle bits pulse once.
- R8: Reads from any offset other than the data window and 0x400 return 0, and writes to those offsets change no state.
- R9: Turning an input pin into an output keeps the last captured level in its data bit, so the pin then drives that level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| pin_in | input | 8 | Asynchronous external pin levels |
| pin_out | output | 8 | Driven pin levels |
| pin_toggle | output | 8 | One-cycle pulse per pin when its driven level flips |

## Verification
Assertions check on every cycle that input pins drive high, that change strobes match exactly the flips of the driven level, that reads never leak bits outside the address mask, that input-pin data tracks the synchronizer, and that unmasked output bits hold. Only the bench's scenarios can show the reset sequence with its initial burst of strobes, the synchronizer latency seen from the pins, the retention of a captured level when a pin turns into an output, and that stray offsets leave every register intact.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_DIR   = 2'd2,
        ACC_OTHER = 2'd3
    } gmp_acc_e;

    // Classify a bus offset: the data window spans 4 bytes per mask pattern,
    // the direction register sits right above it.
    function automatic gmp_acc_e gmp_decode(input logic sel,
                                            input logic [31:0] ofs,
                                            input int unsigned pins);
        logic [31:0] win;
        win = 32'd1 << (pins + 2);
        if (!sel)
            return ACC_NONE;
        else if (ofs < win)
            return ACC_DATA;
        else if (ofs == win)
            return ACC_DIR;
        else
            return ACC_OTHER;
    endfunction

endpackage

// File: rtl/gmp_sync.sv
module gmp_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < STAGES; k++)
            stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++)
                stg_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++)
                stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gmp_regs.sv
module gmp_regs
    import gpio_mp_pkg::*;
#(
    parameter int PINS  = 8,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  gmp_acc_e         acc,
    input  logic             wr,
    input  logic [PINS-1:0]  mask,
    input  logic [PINS-1:0]  wdata,
    input  logic [PINS-1:0]  sync_in,
    output logic [PINS-1:0]  data_q,
    output logic [PINS-1:0]  dir_q,
    output logic [BUS_W-1:0] rdata
);
    typedef struct packed {
        logic [PINS-1:0] data;
        logic [PINS-1:0] dir;
    } regs_t;

    regs_t           cur_q, nxt_d;
    logic [PINS-1:0] wmask_d;

    always_comb begin
        nxt_d = cur_q;
        // input pins follow the synchronized pin level
        for (int i = 0; i < PINS; i++)
            if (!cur_q.dir[i])
                nxt_d.data[i] = sync_in[i];
        // masked software write, output pins only
        wmask_d    = (acc == ACC_DATA && wr) ? (mask & cur_q.dir) : '0;
        nxt_d.data = (nxt_d.data & ~wmask_d) | (wdata & wmask_d);
        if (acc == ACC_DIR && wr)
            nxt_d.dir = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    always_comb begin
        rdata = '0;
        if (!wr) begin
            if (acc == ACC_DATA)
                rdata = BUS_W'(cur_q.data & mask);
            else if (acc == ACC_DIR)
                rdata = BUS_W'(cur_q.dir);
        end
    end

    assign data_q = cur_q.data;
    assign dir_q  = cur_q.dir;

    p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DIR && wr) |=> (dir_q == $past(wdata)));

    p_read_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_DATA && !wr) |-> ((rdata & ~BUS_W'(mask)) == '0));

    p_other_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_OTHER) |-> (rdata == '0));

    for (genvar g = 0; g < PINS; g++) begin : g_chk
        p_input_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!dir_q[g]) |=> (data_q[g] == $past(sync_in[g])));

        p_output_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (dir_q[g] && !(acc == ACC_DATA && wr && mask[g])) |=> $stable(data_q[g]));
    end
endmodule

// File: rtl/gmp_drive.sv
module gmp_drive #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] data_i,
    input  logic [PINS-1:0] dir_i,
    output logic [PINS-1:0] pin_out,
    output logic [PINS-1:0] pin_toggle
);
    typedef struct packed {
        logic [PINS-1:0] lvl;
        logic [PINS-1:0] tog;
    } drv_t;

    drv_t            cur_q, nxt_d;
    logic [PINS-1:0] lvl_d;

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        assign lvl_d[g] = dir_i[g] ? data_i[g] : 1'b1;
    end

    always_comb begin
        nxt_d.lvl = lvl_d;
        nxt_d.tog = lvl_d ^ cur_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= nxt_d;
    end

    assign pin_out    = cur_q.lvl;
    assign pin_toggle = cur_q.tog;

    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pin_toggle == (pin_out ^ $past(pin_out)));

    for (genvar g = 0; g < PINS; g++) begin : g_chk
        p_input_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (!dir_i[g]) |=> pin_out[g]);
    end
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
    import gpio_mp_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_toggle
);
    localparam int MASK_LO = 2;
    localparam int MASK_HI = PINS + MASK_LO - 1;

    gmp_acc_e        acc;
    logic [PINS-1:0] addr_mask;
    logic [PINS-1:0] sync_lvl;
    logic [PINS-1:0] data_q;
    logic [PINS-1:0] dir_q;

    assign acc       = gmp_decode(bus_sel, 32'(bus_addr), PINS);
    assign addr_mask = bus_addr[MASK_HI:MASK_LO];

    gmp_sync #(.W(PINS), .STAGES(SYNC_N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_lvl)
    );

    gmp_regs #(.PINS(PINS), .BUS_W(BUS_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc    (acc),
        .wr     (bus_wr),
        .mask   (addr_mask),
        .wdata  (bus_wdata),
        .sync_in(sync_lvl),
        .data_q (data_q),
        .dir_q  (dir_q),
        .rdata  (bus_rdata)
    );

    gmp_drive #(.PINS(PINS)) u_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (data_q),
        .dir_i     (dir_q),
        .pin_out   (pin_out),
        .pin_toggle(pin_toggle)
    );
endmodule

// File: tb/gpio_masked_port_tb.sv
`timescale 1ns/1ps
module gpio_masked_port_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel;
    logic        bus_wr;
    logic [11:0] bus_addr;
    logic [7:0]  bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in;
    logic [7:0]  pin_out;
    logic [7:0]  pin_toggle;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state, built from the requirements
    logic [7:0] m_data, m_dir, m_out, m_tog, m_s1, m_s2;

    always #4 clk = ~clk;

    gpio_masked_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_toggle(pin_toggle)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        if (a < 12'h400)      return {24'd0, m_data & a[9:2]};
        else if (a == 12'h400) return {24'd0, m_dir};
        else                   return 32'd0;
    endfunction

    function automatic string read_tag(input logic [11:0] a);
        if (a < 12'h400)       return "R1";
        else if (a == 12'h400) return "R4";
        else                   return "R8";
    endfunction

    always @(posedge clk) begin
        logic [7:0] nd, wm, no;
        if (!rst_n) begin
            m_data = '0; m_dir = '0; m_out = '0; m_tog = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            nd = (m_data & m_dir) | (m_s2 & ~m_dir);
            if (bus_sel && bus_wr && bus_addr < 12'h400) begin
                wm = bus_addr[9:2] & m_dir;
                nd = (nd & ~wm) | (bus_wdata & wm);
            end
            no    = (m_data & m_dir) | ~m_dir;
            m_tog = no ^ m_out;
            m_out = no;
            if (bus_sel && bus_wr && bus_addr == 12'h400) m_dir = bus_wdata;
            m_data = nd;
            m_s2   = m_s1;
            m_s1   = pin_in;
        end
    end

    // pin-level comparison every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R5", {24'd0, pin_out}, {24'd0, m_out});
            check("R6", {24'd0, pin_toggle}, {24'd0, m_tog});
        end
    end

    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] lit, input bit use_lit, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(tag, bus_rdata, use_lit ? lit : exp_read(a));
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        repeat (3) @(negedge clk);
        check("R7 out in reset", {24'd0, pin_out}, 32'h0);
        check("R7 strobe in reset", {24'd0, pin_toggle}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 out after reset", {24'd0, pin_out}, 32'hFF);
        check("R7 strobes after reset", {24'd0, pin_toggle}, 32'hFF);
        bus_read(12'h400, 32'h0, 1, "R4 dir reset");
        bus_read(12'h3FC, 32'h0, 1, "R1 data reset");

        bus_write(12'h400, 8'h0F);
        bus_read(12'h400, 32'h0F, 1, "R4 dir readback");
        bus_write(12'h3FC, 8'hA5);
        bus_read(12'h3FC, 32'h05, 1, "R2 full mask write");
        idle(1);
        check("R5 literal levels", {24'd0, pin_out}, 32'hF5);
        bus_write(12'h00C, 8'hFA);
        bus_read(12'h3FC, 32'h06, 1, "R2 partial mask write");
        bus_read(12'h008, 32'h02, 1, "R1 single bit read");
        bus_read(12'h020, 32'h00, 1, "R1 masked out bit");

        pin_in = 8'hC0;
        idle(4);
        bus_write(12'h3FC, 8'h00);
        bus_read(12'h3FC, 32'hC0, 1, "R3 input kept on write");
        bus_write(12'h400, 8'hFF);
        idle(2);
        check("R9 captured level driven", {24'd0, pin_out}, 32'hC0);
        pin_in = 8'h00;
        idle(4);
        bus_read(12'h3FC, 32'hC0, 1, "R9 output ignores pins");

        bus_write(12'h800, 8'h00);
        bus_write(12'h404, 8'h00);
        bus_read(12'h400, 32'hFF, 1, "R8 dir untouched");
        bus_read(12'h3FC, 32'hC0, 1, "R8 data untouched");
        bus_read(12'h404, 32'h0, 1, "R8 other reads zero");

        for (int i = 0; i < 3000; i++) begin
            int unsigned op;
            logic [11:0] a;
            op = $urandom % 8;
            case (op)
                0, 1: bus_write({$urandom % 256, 2'b00}, 8'($urandom));
                2: begin
                    a = 12'($urandom) & 12'hFFC;
                    bus_write(a, 8'($urandom));
                end
                3: bus_write(12'h400, 8'($urandom));
                4: begin
                    a = {$urandom % 256, 2'b00};
                    bus_read(a, 32'h0, 0, read_tag(a));
                end
                5: begin
                    a = ($urandom % 4 == 0) ? 12'h400 : (12'($urandom) & 12'hFFC);
                    bus_read(a, 32'h0, 0, read_tag(a));
                end
                6: begin
                    @(negedge clk);
                    pin_in = 8'($urandom);
                end
                default: idle(1);
            endcase
        end
        idle(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule